// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host request port and an asynchronous 1M x 16 DRAM whose address pins carry the row and then the column. Each 20-bit word address is split: bits 19..10 select the row and bits 9..0 select the column. A sequencer built on a down-counter generates RAS, the upper and lower CAS strobes, WE, OE and the 10-bit address bus. Every interval is a parameter counted in clock cycles.

Once a row has been activated, RAS is held low. Later requests to the same row then run as short column cycles (page mode). A request to a different row closes the page, waits the precharge time and opens the new row. A timer raises a refresh request at a fixed interval, which defaults to 16 ms / 1024 rows at 100 MHz. The request takes priority over host traffic. Refresh is done as a CAS-before-RAS cycle, so the DRAM supplies the row itself and no row address is driven.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While rst_ni is low, RAS, both CAS strobes, WE and OE are high (inactive), the data bus is not driven, and rd_valid_o is low.
- R2: The bus carries addr[19:10] when RAS falls for an access and addr[9:0] when CAS falls. Accesses reach the DRAM in the order they were accepted.
- R3: For an access, at least T_RCD clock samples with RAS low and CAS high come before the first CAS fall after activation.
- R4: Every CAS pulse of an access stays low for at least T_CAS samples. Between consecutive CAS pulses, CAS stays high for at least T_CP samples.
- R5: While a row is open and no refresh has intervened, a request to that row is served by a CAS pulse alone, and RAS stays low. The same row is never re-activated without a refresh in between.
- R6: Before any RAS fall, whether for an activation or a refresh, RAS has been high for at least T_RP samples.
- R7: Byte enable bit 1 drives the upper CAS (data bits 15..8) and bit 0 drives the lower CAS (bits 7..0). Only the strobes of enabled lanes go low. A write changes only the enabled lanes.
- R8: During a read, OE is low and the controller does not drive the bus. Each read returns exactly one single-cycle rd_valid_o pulse, in request order. Enabled lanes carry the stored data and disabled lanes read as zero.
- R9: Refresh is CAS-before-RAS. Both CAS strobes are low at least one sample before RAS falls, and RAS then stays low for at least T_RAS_REF samples.
- R10: Consecutive refresh RAS falls, and the first one after reset, are at most REF_INTERVAL + T_RCD + T_CAS + T_CP + 2*T_RP + 8 cycles apart. This holds even under continuous same-row traffic, which forces the open page to close.
- R11: A request is taken on a clock edge where req_valid_i and req_ready_o are both high. WE is low at the CAS fall exactly when the request was a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_addr_i | input | 20 | Word address, row in bits 19..10 |
| req_be_i | input | 2 | Byte lane enables |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data |
| rd_valid_o | output | 1 | Read data valid, one cycle |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_ucas_n_o | output | 1 | Upper byte column strobe, active low |
| dram_lcas_n_o | output | 1 | Lower byte column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 16 | Data toward the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 16 | Data from the DRAM |

## Verification
The bench contains a behavioural DRAM that latches the row and column on strobe edges, so a wrong address split, lane swap or stale column shows up as a data mismatch on readback. Long runs of same-row traffic check that the page stays open. A controller that re-activated the row, or that skipped refresh while the host kept the port busy, would fail the reopen check or the refresh-gap bound. Row flips, including the corner address 0xFFFFF, measure the precharge and the RAS-to-CAS spacing. Partial byte enables check that a disabled lane is neither written nor returned, and that its CAS strobe never falls.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_COL, S_CPRE, S_OPEN, S_PRE, S_RCAS, S_RRAS
  } fpm_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_delay_cnt.sv
module fpm_delay_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // counter never wraps below zero: a non-loaded zero stays zero
  assert_cnt_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int unsigned W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt_q;
  logic         tick;
  logic         pend_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // a new tick must never land on an unserved request
  assert_no_lost_refresh_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && pend_q) |-> ack_i);
endmodule

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] load_row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      valid_q <= 1'b0;
    end else if (open_i) begin
      row_q   <= load_row_i;
      valid_q <= 1'b1;
    end else if (close_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o = valid_q && (row_q == cmp_row_i);

  assert_open_close_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_i && close_i));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned ROW_W        = 10,
  parameter int unsigned COL_W        = 10,
  parameter int unsigned DW           = 16,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_CAS        = 2,
  parameter int unsigned T_CP         = 1,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_RAS_REF    = 5,
  parameter int unsigned REF_INTERVAL = 1560
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DW/8-1:0]        req_be_i,
  input  logic                   req_we_i,
  input  logic [DW-1:0]          req_wdata_i,
  output logic [DW-1:0]          rd_data_o,
  output logic                   rd_valid_o,
  output logic                   dram_ras_n_o,
  output logic                   dram_ucas_n_o,
  output logic                   dram_lcas_n_o,
  output logic                   dram_we_n_o,
  output logic                   dram_oe_n_o,
  output logic [fpm_pkg::max_u(ROW_W, COL_W)-1:0] dram_addr_o,
  output logic [DW-1:0]          dram_dq_o,
  output logic                   dram_dq_oe_o,
  input  logic [DW-1:0]          dram_dq_i
);
  localparam int unsigned AW    = ROW_W + COL_W;
  localparam int unsigned MAW   = max_u(ROW_W, COL_W);
  localparam int unsigned LANES = DW / 8;
  localparam int unsigned T_MAX = max_u(max_u(max_u(T_RCD, T_CAS), max_u(T_CP, T_RP)), T_RAS_REF);
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  fpm_state_e state_q, state_d;

  logic [ROW_W-1:0] req_row_q;
  logic [COL_W-1:0] req_col_q;
  logic [LANES-1:0] req_be_q;
  logic             req_we_q;
  logic [DW-1:0]    req_wd_q;
  logic             have_req_q;

  logic             ras_n_q, ucas_n_q, lcas_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [MAW-1:0]   addr_q;
  logic [DW-1:0]    dq_q, rd_data_q;
  logic             rd_valid_q;

  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             ref_pend, ref_ack;
  logic             row_open, row_close, row_hit;
  logic [ROW_W-1:0] load_row;
  logic             accept;
  logic [COL_W-1:0] cur_col;
  logic [LANES-1:0] cur_be;
  logic             cur_we;
  logic [DW-1:0]    cur_wd;
  logic [DW-1:0]    rd_masked;

  assign req_ready_o = (state_q == S_IDLE || state_q == S_OPEN) && !ref_pend;
  assign accept      = req_valid_i && req_ready_o;
  assign load_row    = (state_q == S_IDLE) ? req_addr_i[AW-1:COL_W] : req_row_q;
  assign cur_col     = accept ? req_addr_i[COL_W-1:0] : req_col_q;
  assign cur_be      = accept ? req_be_i    : req_be_q;
  assign cur_we      = accept ? req_we_i    : req_we_q;
  assign cur_wd      = accept ? req_wdata_i : req_wd_q;

  fpm_delay_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_load), .val_i(cnt_val), .zero_o(cnt_zero)
  );

  fpm_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .pend_o(ref_pend)
  );

  fpm_row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .open_i(row_open), .close_i(row_close),
    .load_row_i(load_row), .cmp_row_i(req_addr_i[AW-1:COL_W]), .hit_o(row_hit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_masked[l*8 +: 8] = req_be_q[l] ? dram_dq_i[l*8 +: 8] : 8'h00;
  end

  always_comb begin
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    ref_ack   = 1'b0;
    row_open  = 1'b0;
    row_close = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_pend) begin
          state_d = S_RCAS;
          ref_ack = 1'b1;
        end else if (req_valid_i) begin
          state_d  = S_ACT;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_RCD - 1);
          row_open = 1'b1;
        end
      end
      S_ACT: if (cnt_zero) begin
        state_d  = S_COL;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_CAS - 1);
      end
      S_COL: if (cnt_zero) begin
        state_d  = S_CPRE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_CP - 1);
      end
      S_CPRE: if (cnt_zero) state_d = S_OPEN;
      S_OPEN: begin
        if (ref_pend || (req_valid_i && !row_hit)) begin
          state_d   = S_PRE;
          cnt_load  = 1'b1;
          cnt_val   = CNT_W'(T_RP - 1);
          row_close = 1'b1;
        end else if (req_valid_i) begin
          state_d  = S_COL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_CAS - 1);
        end
      end
      S_PRE: if (cnt_zero) begin
        if (have_req_q) begin
          state_d  = S_ACT;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(T_RCD - 1);
          row_open = 1'b1;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_RCAS: begin
        state_d  = S_RRAS;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_RAS_REF - 1);
      end
      S_RRAS: if (cnt_zero) begin
        state_d  = S_PRE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(T_RP - 1);
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      req_row_q  <= '0;
      req_col_q  <= '0;
      req_be_q   <= '0;
      req_we_q   <= 1'b0;
      req_wd_q   <= '0;
      have_req_q <= 1'b0;
      ras_n_q    <= 1'b1;
      ucas_n_q   <= 1'b1;
      lcas_n_q   <= 1'b1;
      we_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      addr_q     <= '0;
      dq_q       <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= 1'b0;
      if (accept) begin
        req_row_q  <= req_addr_i[AW-1:COL_W];
        req_col_q  <= req_addr_i[COL_W-1:0];
        req_be_q   <= req_be_i;
        req_we_q   <= req_we_i;
        req_wd_q   <= req_wdata_i;
        have_req_q <= 1'b1;
      end
      if (state_d != state_q) begin
        unique case (state_d)
          S_ACT: begin
            ras_n_q <= 1'b0;
            addr_q  <= MAW'(load_row);
          end
          S_COL: begin
            have_req_q <= 1'b0;
            addr_q     <= MAW'(cur_col);
            ucas_n_q   <= ~cur_be[1];
            lcas_n_q   <= ~cur_be[0];
            we_n_q     <= ~cur_we;
            oe_n_q     <= cur_we;
            dq_q       <= cur_wd;
            dq_oe_q    <= cur_we;
          end
          S_CPRE: begin
            ucas_n_q <= 1'b1;
            lcas_n_q <= 1'b1;
            we_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            dq_oe_q  <= 1'b0;
            if (!req_we_q) begin
              rd_data_q  <= rd_masked;
              rd_valid_q <= 1'b1;
            end
          end
          S_PRE: begin
            ras_n_q  <= 1'b1;
            ucas_n_q <= 1'b1;
            lcas_n_q <= 1'b1;
          end
          S_RCAS: begin
            ucas_n_q <= 1'b0;
            lcas_n_q <= 1'b0;
            we_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
          end
          S_RRAS:  ras_n_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign rd_data_o     = rd_data_q;
  assign rd_valid_o    = rd_valid_q;
  assign dram_ras_n_o  = ras_n_q;
  assign dram_ucas_n_o = ucas_n_q;
  assign dram_lcas_n_o = lcas_n_q;
  assign dram_we_n_o   = we_n_q;
  assign dram_oe_n_o   = oe_n_q;
  assign dram_addr_o   = addr_q;
  assign dram_dq_o     = dq_q;
  assign dram_dq_oe_o  = dq_oe_q;

  // a RAS fall with CAS already low must have had CAS low beforehand
  assert_cbr_cas_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_q) && !(ucas_n_q && lcas_n_q)) |-> (!$past(ucas_n_q) && !$past(lcas_n_q)));

  assert_cas_idle_outside_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {S_IDLE, S_ACT, S_CPRE, S_OPEN, S_PRE}) |-> (ucas_n_q && lcas_n_q));

  assert_page_ras_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OPEN) |-> !ras_n_q);

  assert_rd_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_q |=> !rd_valid_q);

  assert_no_bus_fight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> !dq_oe_q);
endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_RAS_REF = 5;
  localparam int REF_INTERVAL = 200;
  localparam int SLACK = T_RCD + T_CAS + T_CP + 2 * T_RP + 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o, req_we_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0, rd_data_o, dram_dq_o, dram_dq_i = 16'hBEEF;
  logic rd_valid_o, dram_ras_n_o, dram_ucas_n_o, dram_lcas_n_o, dram_we_n_o, dram_oe_n_o, dram_dq_oe_o;
  logic [9:0] dram_addr_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  fpm_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                  .T_RAS_REF(T_RAS_REF), .REF_INTERVAL(REF_INTERVAL)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_be_i(req_be_i), .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .dram_ras_n_o(dram_ras_n_o),
    .dram_ucas_n_o(dram_ucas_n_o), .dram_lcas_n_o(dram_lcas_n_o), .dram_we_n_o(dram_we_n_o),
    .dram_oe_n_o(dram_oe_n_o), .dram_addr_o(dram_addr_o), .dram_dq_o(dram_dq_o),
    .dram_dq_oe_o(dram_dq_oe_o), .dram_dq_i(dram_dq_i)
  );

  typedef struct { logic [19:0] a; logic we; logic [1:0] be; logic [15:0] wd; } req_t;
  req_t        acc_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] dram_mem[int];
  logic [15:0] ref_mem[int];

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_ge(input string rq, input int act, input int lim);
    n_checks++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected >= %0d", rq, act, lim);
    end
  endtask

  task automatic chk_le(input string rq, input int act, input int lim);
    n_checks++;
    if (act > lim) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected <= %0d", rq, act, lim);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // behavioural DRAM and protocol observer, sampled on the falling clock
  int cyc = 0, last_ref = 0, n_ref = 0, hits = 0;
  int ras_low_cnt = 0, ras_high_cnt = 1000, cas_low_cnt = 0, cas_high_cnt = 1000;
  logic ras_p = 1'b1, cas_p = 1'b0;
  logic [9:0] cur_row = '0, cur_col = '0, last_row = '0;
  bit in_ref = 0, page_valid = 0, act_pend = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic ras, cas;
      int idx;
      logic [15:0] w;
      req_t r;
      cyc++;
      ras = dram_ras_n_o;
      cas = !(dram_ucas_n_o && dram_lcas_n_o);
      if (ras_p && !ras) begin
        chk_ge("R6 precharge", ras_high_cnt, T_RP);
        if (cas) begin
          chk("R9 cas before ras", {31'd0, cas_p}, 32'd1);
          chk_le("R10 refresh gap", cyc - last_ref, REF_INTERVAL + SLACK);
          last_ref = cyc; n_ref++; in_ref = 1; page_valid = 0;
        end else begin
          cur_row = dram_addr_o;
          chk("R5 needless reopen", {31'd0, page_valid && cur_row == last_row}, 32'd0);
          if (acc_q.size() == 0) chk("R2 activation without request", 1, 0);
          else chk("R2 row addr", {22'd0, cur_row}, {22'd0, acc_q[0].a[19:10]});
          last_row = cur_row; page_valid = 1; act_pend = 1;
        end
      end
      if (cas_p && !cas && !in_ref) chk_ge("R4 cas width", cas_low_cnt, T_CAS);
      if (!ras_p && ras && in_ref) begin
        chk_ge("R9 refresh ras width", ras_low_cnt, T_RAS_REF);
        in_ref = 0;
      end
      if (!cas_p && cas && !ras) begin
        chk_ge("R4 cas precharge", cas_high_cnt, T_CP);
        if (act_pend) chk_ge("R3 ras to cas", ras_low_cnt, T_RCD);
        else hits++;
        act_pend = 0;
        cur_col = dram_addr_o;
        if (acc_q.size() == 0) chk("R2 cas without request", 1, 0);
        else begin
          r = acc_q.pop_front();
          chk("R2 col addr", {22'd0, cur_col}, {22'd0, r.a[9:0]});
          chk("R2 row of access", {22'd0, cur_row}, {22'd0, r.a[19:10]});
          chk("R7 lane strobes", {30'd0, !dram_ucas_n_o, !dram_lcas_n_o}, {30'd0, r.be});
          chk("R11 write flag", {31'd0, dram_we_n_o}, {31'd0, !r.we});
          idx = {cur_row, cur_col};
          if (r.we) begin
            chk("R7 write data", {15'd0, dram_dq_oe_o, dram_dq_o & lane_mask(r.be)},
                {15'd0, 1'b1, r.wd & lane_mask(r.be)});
            w = dram_mem.exists(idx) ? dram_mem[idx] : 16'h0;
            dram_mem[idx] = (w & ~lane_mask(r.be)) | (dram_dq_o & lane_mask(r.be));
          end else begin
            chk("R8 oe low on read", {31'd0, dram_oe_n_o}, 32'd0);
          end
        end
      end
      if (rd_valid_o) begin
        if (exp_q.size() == 0) chk("R8 spurious rd_valid", 1, 0);
        else chk("R8 read data", {16'd0, rd_data_o}, {16'd0, exp_q.pop_front()});
      end
      if (ras) begin ras_high_cnt++; ras_low_cnt = 0; end
      else begin ras_low_cnt++; ras_high_cnt = 0; end
      if (cas) begin cas_low_cnt++; cas_high_cnt = 0; end
      else begin cas_high_cnt++; cas_low_cnt = 0; end
      ras_p = ras; cas_p = cas;
      idx = {cur_row, cur_col};
      if (cas && !ras && !dram_oe_n_o && dram_we_n_o) begin
        w = dram_mem.exists(idx) ? dram_mem[idx] : 16'h0;
        dram_dq_i = {dram_ucas_n_o ? 8'hA5 : w[15:8], dram_lcas_n_o ? 8'h5A : w[7:0]};
      end else begin
        dram_dq_i = 16'hBEEF;
      end
    end
  end

  task automatic host(input logic [19:0] a, input logic we, input logic [1:0] be, input logic [15:0] wd);
    req_t r;
    logic [15:0] w;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_we_i = we; req_be_i = be; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    r.a = a; r.we = we; r.be = be; r.wd = wd;
    acc_q.push_back(r);
    w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
    if (we) ref_mem[int'(a)] = (w & ~lane_mask(be)) | (wd & lane_mask(be));
    else exp_q.push_back(w & lane_mask(be));
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  int wd_cnt = 0;
  always @(posedge clk_i) begin
    wd_cnt++;
    if (wd_cnt == 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 ras", {31'd0, dram_ras_n_o}, 1);
    chk("R1 cas", {30'd0, dram_ucas_n_o, dram_lcas_n_o}, 3);
    chk("R1 we/oe", {30'd0, dram_we_n_o, dram_oe_n_o}, 3);
    chk("R1 bus", {30'd0, dram_dq_oe_o, rd_valid_o}, 0);
    rst_ni = 1'b1;

    // page mode writes and reads in one row (R5, R2, R8)
    for (int i = 0; i < 8; i++) host({10'd5, 10'(i)}, 1, 2'b11, 16'h1000 + 16'(i * 17));
    for (int i = 0; i < 8; i++) host({10'd5, 10'(i)}, 0, 2'b11, 16'h0);
    // byte lanes (R7, R8)
    host({10'd5, 10'd20}, 1, 2'b11, 16'hC3C3);
    host({10'd5, 10'd20}, 1, 2'b01, 16'h1234);
    host({10'd5, 10'd20}, 1, 2'b10, 16'hAB99);
    host({10'd5, 10'd20}, 0, 2'b11, 16'h0);
    host({10'd5, 10'd20}, 0, 2'b01, 16'h0);
    host({10'd5, 10'd20}, 0, 2'b10, 16'h0);
    // row misses and address corners (R6, R3, R2)
    host(20'hFFFFF, 1, 2'b11, 16'h7E81);
    host(20'h00000, 1, 2'b11, 16'h0F0F);
    host({10'd900, 10'd3}, 1, 2'b11, 16'h5555);
    host(20'hFFFFF, 0, 2'b11, 16'h0);
    host(20'h00000, 0, 2'b11, 16'h0);
    host({10'd5, 10'd3}, 0, 2'b11, 16'h0);
    host({10'd900, 10'd3}, 0, 2'b11, 16'h0);
    // long same-row stream that refresh must break into (R10, R5)
    for (int i = 0; i < 160; i++) host({10'd77, 10'(i % 32)}, (i % 3) != 0, 2'(1 + i % 3), 16'(i * 331));
    for (int i = 0; i < 32; i++) host({10'd77, 10'(i)}, 0, 2'b11, 16'h0);
    // idle period: refresh continues alone (R9, R10)
    repeat (3 * REF_INTERVAL) @(negedge clk_i);
    chk("R8 all reads returned", exp_q.size(), 0);
    chk("R11 all requests issued", acc_q.size(), 0);
    chk_ge("R5 page hits", hits, 150);
    chk_ge("R10 refresh count", n_ref, cyc / REF_INTERVAL - 1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule